// File: doc/BRIEF.md
# Chained Serial Converter Input Front End

This block is the digital input stage of a 12-bit converter whose loading is serial and which can sit in a chain of identical devices. Bits arrive one at a time on a serial input and move into a shift register. The most significant bit of that register drives a serial output, which feeds the next device in the chain. As a new word shifts in, the word that was held before leaves the chain output most significant bit first. Several shared wires can then reach any number of converters: a data line into the first device, a strobe, and a load line.

Shifting can be clocked by any of four strobe pins, and each pin has its own idle level. Strobes 0, 1 and 3 idle high and shift on a rising edge. Strobe 2 idles low and shifts on a falling edge. The shift register moves into the converter holding register only while both load inputs are low. This lets every device in a chain update at the same moment. An asynchronous clear zeroes the holding register and leaves the shift register alone. The whole block runs on a fast system clock. Every strobe, load and data pin passes through a synchronizer before edges are detected. The clear and the reset bypass this path.

Top module: `chain_dac_front`

## Requirements
- R1: While `rst_n` is low, the shift register and `dac_word` are zero and `sdo` is low.
- R2: A shift happens when strobe pin 0, 1 or 3 rises to 1, or when strobe pin 2 falls to 0. On a shift, every bit of the shift register moves one place toward the MSB and bit 0 takes the synchronized `sdi`.
- R3: `sdo` always shows the MSB of the shift register. The word held before a sequence of WORD_W shifts therefore leaves `sdo` MSB first, one bit per shift, with bit WORD_W-1 visible before the first shift.
- R4: A strobe that moves away from its idle level causes no shift.
- R5: Active edges on several strobe pins that are synchronized in the same clock cycle cause exactly one shift.
- R6: In every cycle where both synchronized load inputs are low, `dac_word` takes the shift register. If only one load input is low, `dac_word` keeps its value.
- R7: If a load and a shift happen in the same cycle, `dac_word` takes the shift register value from before that shift.
- R8: A low level on `clr_n` forces `dac_word` to zero at once, without a clock edge. The shift register keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pin sampling and register updates use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| clr_n | input | 1 | Asynchronous active-low clear of the holding register only |
| sdi | input | 1 | Serial data in, captured on each shift |
| stb | input | 4 | Strobe pins; bits 0, 1, 3 idle high and shift on rise, bit 2 idles low and shifts on fall |
| ld_a_n | input | 1 | First load input, active low |
| ld_b_n | input | 1 | Second load input, active low |
| sdo | output | 1 | Serial chain output, the shift register MSB |
| dac_word | output | WORD_W | Holding register that drives the converter |

## Verification
The bench uses the default parameters: a 12-bit word, two synchronizer stages, and strobe idle mask 4'b1011. With these values each test vector can drive a full word through every strobe pin, including the falling-edge one. The bench then checks the old word as it leaves `sdo`. Because the two-stage latency is short, the bench can line up a load with a shift edge in the same cycle. The same short latency lets it hold a strobe away from idle, apply a clear that spans clock edges, and give two strobes coincident edges, all with exact expected values.

// File: rtl/chain_dac_front.sv
module chain_dac_front #(
  parameter int         WORD_W      = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] STB_IDLE    = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              sdi,
  input  logic [3:0]        stb,
  input  logic              ld_a_n,
  input  logic              ld_b_n,
  output logic              sdo,
  output logic [WORD_W-1:0] dac_word
);

  localparam int         NPIN     = 7;
  localparam logic [NPIN-1:0] PIN_IDLE = {2'b11, 1'b0, STB_IDLE};

  logic [NPIN-1:0] raw_pins;
  logic [NPIN-1:0] sync_q [SYNC_STAGES];
  logic [NPIN-1:0] pins_s;
  logic [3:0]      stb_prev;
  logic [3:0]      stb_arrive;
  logic            shift_evt;
  logic            load_evt;
  logic [WORD_W-1:0] shreg;

  assign raw_pins = {ld_b_n, ld_a_n, sdi, stb};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sync_q[g] <= PIN_IDLE;
      else if (g == 0) sync_q[g] <= raw_pins;
      else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  assign pins_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_prev <= STB_IDLE;
    else        stb_prev <= pins_s[3:0];
  end

  assign stb_arrive = ~(pins_s[3:0] ^ STB_IDLE) & (stb_prev ^ STB_IDLE);
  assign shift_evt  = |stb_arrive;
  assign load_evt   = ~pins_s[5] & ~pins_s[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shreg <= '0;
    else if (shift_evt) shreg <= {shreg[WORD_W-2:0], pins_s[4]};
  end

  always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
    if (!rst_n || !clr_n) dac_word <= '0;
    else if (load_evt)    dac_word <= shreg;
  end

  assign sdo = shreg[WORD_W-1];

endmodule

module chain_dac_front_chk #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              shift_evt,
  input logic              load_evt,
  input logic [WORD_W-1:0] shreg,
  input logic [WORD_W-1:0] dac_word
);

  a_r2_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> shreg[WORD_W-1:1] == $past(shreg[WORD_W-2:0]));

  a_r4_no_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(shreg));

  a_r7_load_takes_old: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    load_evt |=> dac_word == $past(shreg));

  a_r6_no_load_hold: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !load_evt |=> $stable(dac_word));

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_word == '0);

  a_r8_clear_keeps_shreg: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !shift_evt) |=> $stable(shreg));

endmodule

bind chain_dac_front chain_dac_front_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .shift_evt(shift_evt),
  .load_evt(load_evt), .shreg(shreg), .dac_word(dac_word)
);

// File: tb/sim_chain_dac_front.sv
module sim_chain_dac_front;
  localparam int         W    = 12;
  localparam logic [3:0] IDLE = 4'b1011;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_n = 1'b1, sdi = 1'b0, ld_a_n = 1'b1, ld_b_n = 1'b1;
  logic [3:0] stb = IDLE;
  logic sdo;
  logic [W-1:0] dac_word;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  chain_dac_front u0 (.clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sdi(sdi), .stb(stb),
    .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .sdo(sdo), .dac_word(dac_word));

  // {strobe index, word}
  localparam logic [13:0] VEC [6] = '{
    {2'd0, 12'hA5C}, {2'd1, 12'h3F1}, {2'd2, 12'hFFF},
    {2'd3, 12'h000}, {2'd2, 12'h801}, {2'd0, 12'h7E6}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int idx, input logic b);
    sdi = b;
    stb[idx] = ~IDLE[idx];
    cyc(4);
    stb[idx] = IDLE[idx];
    cyc(4);
  endtask

  task automatic load();
    ld_a_n = 1'b0; ld_b_n = 1'b0;
    cyc(4);
    ld_a_n = 1'b1; ld_b_n = 1'b1;
    cyc(4);
  endtask

  task automatic shift_word(input int idx, input logic [W-1:0] word, input logic [W-1:0] prev, input string tag);
    logic [W-1:0] seen;
    for (int k = W-1; k >= 0; k--) begin
      seen[k] = sdo;
      pulse(idx, word[k]);
    end
    chk(tag, seen, prev);
  endtask

  initial begin
    logic [W-1:0] prev;
    prev = '0;
    cyc(3);
    chk("R1 reset dac_word", dac_word, 0);
    chk("R1 reset sdo", sdo, 0);
    rst_n = 1'b1;
    cyc(2);

    for (int v = 0; v < 6; v++) begin
      shift_word(int'(VEC[v][13:12]), VEC[v][11:0], prev, "R3 old word on sdo");
      chk("R2 word after load", dac_word, prev);
      load();
      chk("R2 R6 word loaded", dac_word, VEC[v][11:0]);
      prev = VEC[v][11:0];
    end

    shift_word(1, 12'h155, 12'h7E6, "R3 old word on sdo");
    ld_a_n = 1'b0; cyc(6);
    chk("R6 only first load low", dac_word, 12'h7E6);
    ld_a_n = 1'b1; ld_b_n = 1'b0; cyc(6);
    chk("R6 only second load low", dac_word, 12'h7E6);
    ld_b_n = 1'b1; cyc(4);
    load();
    chk("R6 both loads low", dac_word, 12'h155);

    #1 clr_n = 1'b0;
    #1 chk("R8 async clear", dac_word, 0);
    cyc(2);
    clr_n = 1'b1;
    cyc(2);
    chk("R8 clear holds", dac_word, 0);
    load();
    chk("R8 shift register intact", dac_word, 12'h155);

    sdi = 1'b1;
    stb[0] = 1'b0; cyc(6);
    load();
    chk("R4 leaving idle no shift", dac_word, 12'h155);
    stb[0] = 1'b1; cyc(4);
    load();
    chk("R2 return to idle shifts", dac_word, 12'h2AB);

    sdi = 1'b0;
    stb[0] = 1'b0; stb[2] = 1'b1; cyc(4);
    stb[0] = 1'b1; stb[2] = 1'b0; cyc(4);
    load();
    chk("R5 coincident edges one shift", dac_word, 12'h556);

    sdi = 1'b1;
    stb[1] = 1'b0; cyc(4);
    stb[1] = 1'b1; ld_a_n = 1'b0; ld_b_n = 1'b0;
    cyc(1);
    ld_a_n = 1'b1; ld_b_n = 1'b1;
    cyc(6);
    chk("R7 same-cycle load takes old", dac_word, 12'h556);
    load();
    chk("R7 shift still applied", dac_word, 12'hAAD);
    chk("R3 sdo is msb", sdo, 1);

    rst_n = 1'b0;
    cyc(1);
    chk("R1 mid-run reset dac_word", dac_word, 0);
    chk("R1 mid-run reset sdo", sdo, 0);
    rst_n = 1'b1;
    cyc(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule